// File: doc/BRIEF.md
# Link-side PHY receive decoder

This block sits on the link side of an 8-bit PHY-to-link interface and runs on the PHY system clock. It only observes the interface. It watches the 2-bit control bus and the 8-bit data bus that the PHY drives, and it never drives either of them. When a receive operation begins, the block skips the data-on indication bytes. It decodes the first ordinary byte as the speed code. It then passes every later byte to the link as one data beat, with strobes that mark the first and the last beat.

The block flags three other events. A receive that ends while the data-on indication is still present is reported as a null packet. A speed byte that matches no known pattern raises an error, and the rest of that packet is discarded. A receive that cuts into a status transfer, with no idle cycle between them, pulses a status-aborted output. The status bits themselves are never reported as data.

Top module: `phy_rx_decoder`

## Requirements
- R1: While reset is asserted, and after reset until a receive is seen, the outputs `beat_valid`, `beat_first`, `beat_last`, `speed_stb`, `speed_err`, `null_stb` and `status_abort` are all 0.
- R2: The control bus uses these codes: 00 idle, 01 status, 10 receive, 11 grant. A receive code may follow idle or status. If it directly follows a status cycle, `status_abort` is 1 for the one cycle after the edge where that receive code is sampled. A status transfer that returns to idle gives no `status_abort`.
- R3: Bytes with bit 7 set, sampled during receive before the speed code, are data-on indications. They produce no beat, no speed strobe and no error.
- R4: The first byte with bit 7 clear after data-on is the speed code. 00xxxxxx gives `speed`=0 (100 Mb/s), 0100xxxx gives `speed`=1 (200 Mb/s), and 01010000 gives `speed`=2 (400 Mb/s). `speed_stb` is 1 for the one cycle after the edge that samples the code, and `speed` holds its value until the next valid code.
- R5: A speed byte with bit 7 clear that matches none of the R4 patterns pulses `speed_err` for one cycle after it is sampled. No beat is produced until a new receive begins.
- R6: After a valid speed code, each byte sampled during receive appears once, in order, on `beat_data` with `beat_valid` set. A byte sampled at edge k is presented in the cycle after edge k+1. `beat_first` marks the first beat of the packet.
- R7: The last byte of a packet is presented with `beat_last` set, in the cycle after the edge where a non-receive control code is first sampled. A packet of one byte has `beat_first` and `beat_last` on the same beat.
- R8: If the control bus leaves receive while data-on bytes are still being sampled, `null_stb` pulses for one cycle after that edge and no beat or speed strobe occurs. At most one of `speed_stb`, `speed_err` and `null_stb` is set in any cycle.
- R9: A packet that ends directly after its speed code produces no beat and no `beat_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl | input | 2 | Control bus from the PHY |
| d | input | 8 | Data bus from the PHY |
| beat_valid | output | 1 | A packet byte is on `beat_data` |
| beat_data | output | 8 | Packet byte |
| beat_first | output | 1 | First beat of a packet |
| beat_last | output | 1 | Final beat of a packet |
| speed | output | 2 | Decoded speed: 0 = 100, 1 = 200, 2 = 400 Mb/s |
| speed_stb | output | 1 | A valid speed code was just decoded |
| speed_err | output | 1 | The speed byte matched no pattern |
| null_stb | output | 1 | Null packet received |
| status_abort | output | 1 | A receive cut into a status transfer |

## Verification
Each event strobe (speed, error, null, abort) is due in the cycle right after the edge that samples its cause. A data beat is due one edge later than that, because each byte waits one cycle to learn whether it is the last one. The bench drives and samples on the falling edge. A behavioural model keeps the packet bytes in a queue and advances by one step for each rising edge. Every falling edge, all outputs are compared with the model's values for the edge that has just passed, so no check depends on guessing a delay.

// File: rtl/phy_rx_decoder.sv
module phy_rx_decoder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ctl,
  input  logic [DW-1:0] d,
  output logic          beat_valid,
  output logic [DW-1:0] beat_data,
  output logic          beat_first,
  output logic          beat_last,
  output logic [1:0]    speed,
  output logic          speed_stb,
  output logic          speed_err,
  output logic          null_stb,
  output logic          status_abort
);
  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_STAT = 2'b01;
  localparam logic [1:0] C_RX   = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_WAIT, S_DON, S_DATA, S_DROP} st_t;
  st_t st;

  logic [DW-1:0] pend;
  logic          pend_ok;
  logic          first;

  wire is_don = d[7];
  wire is400  = d[7:0] == 8'h50;
  wire is200  = d[7:4] == 4'h4;
  wire is100  = d[7:6] == 2'b00;
  wire spd_ok = is400 | is200 | is100;
  wire [1:0] spd_dec = is400 ? 2'd2 : (is200 ? 2'd1 : 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      pend         <= '0;
      pend_ok      <= 1'b0;
      first        <= 1'b0;
      beat_valid   <= 1'b0;
      beat_data    <= '0;
      beat_first   <= 1'b0;
      beat_last    <= 1'b0;
      speed        <= 2'd0;
      speed_stb    <= 1'b0;
      speed_err    <= 1'b0;
      null_stb     <= 1'b0;
      status_abort <= 1'b0;
    end else begin
      beat_valid   <= 1'b0;
      beat_first   <= 1'b0;
      beat_last    <= 1'b0;
      speed_stb    <= 1'b0;
      speed_err    <= 1'b0;
      null_stb     <= 1'b0;
      status_abort <= 1'b0;
      if (ctl == C_RX) begin
        case (st)
          S_IDLE, S_STAT: begin
            status_abort <= (st == S_STAT);
            st <= is_don ? S_DON : S_WAIT;
          end
          S_WAIT: if (is_don) st <= S_DON;
          S_DON: if (!is_don) begin
            if (spd_ok) begin
              speed     <= spd_dec;
              speed_stb <= 1'b1;
              first     <= 1'b1;
              st        <= S_DATA;
            end else begin
              speed_err <= 1'b1;
              st        <= S_DROP;
            end
          end
          S_DATA: begin
            if (pend_ok) begin
              beat_valid <= 1'b1;
              beat_data  <= pend;
              beat_first <= first;
              first      <= 1'b0;
            end
            pend    <= d;
            pend_ok <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        if (st == S_DATA && pend_ok) begin
          beat_valid <= 1'b1;
          beat_data  <= pend;
          beat_first <= first;
          beat_last  <= 1'b1;
        end
        if (st == S_DON) null_stb <= 1'b1;
        pend_ok <= 1'b0;
        first   <= 1'b0;
        st      <= (ctl == C_STAT) ? S_STAT : S_IDLE;
      end
    end
  end

  assert_abort_from_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_abort |-> ($past(ctl) == C_RX && $past(ctl, 2) == C_STAT));

  assert_speed_from_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    speed_stb |-> ($past(ctl) == C_RX && !$past(d[7])));

  assert_err_drops_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    speed_err |=> !beat_valid);

  assert_last_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> (beat_valid && $past(ctl) != C_RX));

  assert_null_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    null_stb |-> ($past(ctl) != C_RX && !beat_valid));

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({speed_stb, speed_err, null_stb}));

  assert_idle_ctl_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl) == C_IDLE && $past(ctl, 2) == C_IDLE) |-> !beat_valid && !speed_stb && !status_abort);
endmodule

// File: tb/phy_rx_decoder_tb.sv
module phy_rx_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [7:0] d = 8'h00;
  logic beat_valid, beat_first, beat_last, speed_stb, speed_err, null_stb, status_abort;
  logic [7:0] beat_data;
  logic [1:0] speed;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state: 0 idle, 1 status, 2 wait data-on, 3 data-on, 4 data, 5 drop
  int m = 0;
  int nbeats = 0;
  int m_speed = 0;
  byte unsigned q[$];
  int e_valid, e_data, e_first, e_last, e_stb, e_err, e_null, e_abort;

  always #10 clk = ~clk;

  phy_rx_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .d(d),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_first(beat_first),
    .beat_last(beat_last), .speed(speed), .speed_stb(speed_stb),
    .speed_err(speed_err), .null_stb(null_stb), .status_abort(status_abort)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(beat_valid == e_valid, "R6 beat_valid", beat_valid, e_valid);
    if (e_valid != 0) begin
      chk(beat_data == e_data, "R6 beat_data", beat_data, e_data);
      chk(beat_first == e_first, "R6 beat_first", beat_first, e_first);
    end
    chk(beat_last == e_last, "R7 beat_last", beat_last, e_last);
    chk(speed_stb == e_stb, "R4 speed_stb", speed_stb, e_stb);
    chk(speed == m_speed, "R4 speed", speed, m_speed);
    chk(speed_err == e_err, "R5 speed_err", speed_err, e_err);
    chk(null_stb == e_null, "R8 null_stb", null_stb, e_null);
    chk(status_abort == e_abort, "R2 status_abort", status_abort, e_abort);
  endtask

  task automatic model(input logic [1:0] c, input logic [7:0] b);
    e_valid = 0; e_first = 0; e_last = 0; e_stb = 0; e_err = 0; e_null = 0; e_abort = 0;
    if (c == 2'b10) begin
      if (m == 0 || m == 1) begin
        e_abort = (m == 1) ? 1 : 0;
        m = b[7] ? 3 : 2;
      end else if (m == 2) begin
        if (b[7]) m = 3;
      end else if (m == 3) begin
        if (!b[7]) begin
          if (b == 8'h50) begin m_speed = 2; e_stb = 1; m = 4; end
          else if (b >= 8'h40 && b <= 8'h4F) begin m_speed = 1; e_stb = 1; m = 4; end
          else if (b < 8'h40) begin m_speed = 0; e_stb = 1; m = 4; end
          else begin e_err = 1; m = 5; end
          nbeats = 0;
          q.delete();
        end
      end else if (m == 4) begin
        q.push_back(b);
        if (q.size() > 1) begin
          e_valid = 1; e_data = q.pop_front(); e_first = (nbeats == 0); nbeats++;
        end
      end
    end else begin
      if (m == 4 && q.size() > 0) begin
        e_valid = 1; e_data = q.pop_front(); e_first = (nbeats == 0); e_last = 1; nbeats++;
      end
      if (m == 3) e_null = 1;
      q.delete();
      m = (c == 2'b01) ? 1 : 0;
    end
  endtask

  task automatic cyc(input logic [1:0] c, input logic [7:0] b);
    @(negedge clk);
    compare_all();
    ctl = c;
    d = b;
    model(c, b);
  endtask

  task automatic pkt(input int ndon, input logic [7:0] spd, input int n, input logic [7:0] base);
    for (int i = 0; i < ndon; i++) cyc(2'b10, 8'hFF);
    cyc(2'b10, spd);
    for (int i = 0; i < n; i++) cyc(2'b10, base + 8'(i * 7));
    cyc(2'b00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(beat_valid == 0 && beat_first == 0 && beat_last == 0, "R1 beats in reset", beat_valid, 0);
    chk(speed_stb == 0 && speed_err == 0 && null_stb == 0 && status_abort == 0, "R1 strobes in reset", speed_stb, 0);
    @(negedge clk);
    rst_n = 1'b1;
    e_valid = 0; e_data = 0; e_first = 0; e_last = 0; e_stb = 0; e_err = 0; e_null = 0; e_abort = 0;
    repeat (3) cyc(2'b00, 8'h00);

    // R8: null packet, one data-on cycle
    cyc(2'b10, 8'h80); cyc(2'b00, 8'h00);
    cyc(2'b00, 8'h00);
    // R3 R4 R6 R7: 400 Mb/s, two data-on cycles, four bytes
    pkt(2, 8'h50, 4, 8'h11);
    cyc(2'b00, 8'h00);
    // R4: 100 Mb/s with don't-care bits set
    pkt(1, 8'h3F, 3, 8'hA0);
    cyc(2'b00, 8'h00);
    // R4 R7: 200 Mb/s single byte, first and last together
    pkt(3, 8'h4A, 1, 8'hC3);
    cyc(2'b00, 8'h00);
    // R5: bad speed 0x51, bytes discarded
    pkt(1, 8'h51, 3, 8'h22);
    cyc(2'b00, 8'h00);
    // R5: bad speed 0x60
    pkt(2, 8'h60, 2, 8'h05);
    // R9: speed code only
    pkt(1, 8'h50, 0, 8'h00);
    cyc(2'b00, 8'h00);
    // R2: status cut by receive, then null
    cyc(2'b01, 8'h01); cyc(2'b01, 8'h00);
    cyc(2'b10, 8'hFF); cyc(2'b10, 8'hFF); cyc(2'b00, 8'h00);
    cyc(2'b00, 8'h00);
    // R2: status completes normally, no abort
    cyc(2'b01, 8'h03); cyc(2'b01, 8'h02); cyc(2'b00, 8'h00);
    cyc(2'b00, 8'h00);
    // R2 R6: status cut by receive carrying a full packet
    cyc(2'b01, 8'h00);
    pkt(1, 8'h00, 2, 8'h77);
    // back-to-back packets with one idle cycle
    pkt(1, 8'h50, 2, 8'h31);
    pkt(1, 8'h41, 3, 8'h90);
    // receive ended by grant
    cyc(2'b10, 8'hFF); cyc(2'b10, 8'h50); cyc(2'b10, 8'h5A); cyc(2'b10, 8'h5B); cyc(2'b11, 8'h00);
    repeat (4) cyc(2'b00, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule